// File: doc/BRIEF.md
# Write-Protected Serial Register Port

This block is a four-wire serial slave that lets a host controller read and write a bank of 64 registers, each 24 bits wide. Every transaction is exactly 32 serial clocks long. An 8-bit command comes first, carrying a 2-bit opcode and a 6-bit register address. It is followed by 24 data bits. The serial pins are not used as clocks: chip select, serial clock and serial data in pass through a synchronizer in the system clock, and edges of the serial clock are found by comparing successive samples.

The address space has five regions:
- Read-only status words at the bottom.
- A block of calibration registers, which accept writes only while a key register holds the unlock value.
- General storage, which is always writable.
- Four special registers at the top: a mirror of the last read data, a mirror of the last written data, a running checksum of the calibration block, and the write-protect key itself.

The two mirrors and the checksum let the host confirm that a transfer arrived intact and that the calibration contents have not changed.

Top module: `cal_spi_port`

## Requirements
- R1: A frame is an 8-bit command sent MSB first, followed by 24 data bits sent MSB first. Serial data in is sampled on rising serial-clock edges. In the command, bits 7:6 are the opcode (00 = read, 01 = write) and bits 5:0 are the register address.
- R2: During a read, serial data out stays low for the 8 command clocks. On each of rising edges 9 to 32 it then presents the next bit of the addressed register, MSB first, within 3 system cycles of the edge. Registers narrower than 24 bits read with zeros in the upper bits; for example, the key register reads as 0x0000KK.
- R3: A write takes effect only at the 32nd rising edge, and only if chip select is still low at that edge. Raising chip select earlier leaves every register unchanged. Rising edges after the 32nd have no effect.
- R4: The write-protect key is at address 0x3F and resets to 0x00. A write to it is always accepted and stores data bits 7:0. The calibration registers at 0x10 to 0x2F change only while the key equals 0x55.
- R5: The checksum at 0x3E resets to 0. It always equals the sum, modulo 2^24, of the calibration registers at 0x10 to 0x2F, and it updates in the same cycle as the calibration register it reflects.
- R6: The last-read mirror at 0x3C holds the 24 data bits returned by the most recent completed read frame.
- R7: The last-write mirror at 0x3D holds the data field of the most recent completed write frame, whether or not the target register accepted it.
- R8: Addresses 0x00 to 0x0F are read-only status words. Each reads as its address repeated in all three bytes, so 0x05 reads as 0x050505. Writes to these addresses, to the two mirrors and to the checksum are ignored.
- R9: General storage at 0x30 to 0x3B resets to 0 and accepts writes regardless of the key.
- R10: A frame with opcode 10 or 11 changes no register and no mirror, and serial data out stays low for its whole length.
- R11: Serial data out is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
A rising serial-clock edge reaches serial data out 3 system cycles after the pin changes: two synchronizer stages, then the output register. The bench therefore holds each serial-clock level for 8 system cycles and samples the output at the end of the high phase, clear of the update. A committed write changes the register bank 4 system cycles after the 32nd rising edge, and the checksum moves in that same cycle. Every frame ends with 8 idle cycles before chip select rises and 8 more afterwards, so read-back frames and the idle-output check always see settled state.

// File: rtl/cal_spi_pkg.sv
package cal_spi_pkg;
    localparam int ADDR_W_DEF = 6;
    localparam int DATA_W_DEF = 24;
    localparam int CMD_W_DEF  = 8;
    localparam int KEY_W_DEF  = 8;

    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;

    localparam logic [7:0] UNLOCK_VALUE = 8'h55;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sclk_pin,
    input  logic mosi_pin,
    output logic cs_n_s,
    output logic sclk_rise,
    output logic mosi_s
);
    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] di;
        logic              ck_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.cs      = {sync_q.cs[STAGES-2:0], cs_n_pin};
        sync_d.ck      = {sync_q.ck[STAGES-2:0], sclk_pin};
        sync_d.di      = {sync_q.di[STAGES-2:0], mosi_pin};
        sync_d.ck_prev = sync_q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.cs      <= '1;
            sync_q.ck      <= '0;
            sync_q.di      <= '0;
            sync_q.ck_prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cs_n_s    = sync_q.cs[STAGES-1];
    assign mosi_s    = sync_q.di[STAGES-1];
    assign sclk_rise = sync_q.ck[STAGES-1] & ~sync_q.ck_prev;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import cal_spi_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int CMD_W  = CMD_W_DEF,
    localparam int FRAME_W = CMD_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rdata,
    output logic              miso,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rcap,
    output logic [CNT_W-1:0]  bit_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0]  tx;
        logic [DATA_W-1:0]  rcap;
        logic [DATA_W-1:0]  wdata;
        logic [1:0]         op;
        logic [ADDR_W-1:0]  addr;
        logic               load_pend;
        logic               dout;
        logic               wr_stb;
        logic               rd_stb;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [FRAME_W-1:0] sh_next;

    always_comb begin
        eng_d        = eng_q;
        eng_d.wr_stb = 1'b0;
        eng_d.rd_stb = 1'b0;
        sh_next      = {eng_q.sh[FRAME_W-2:0], mosi_s};
        if (cs_n_s) begin
            // idle: frame position cleared, output parked low
            eng_d.cnt       = '0;
            eng_d.dout      = 1'b0;
            eng_d.tx        = '0;
            eng_d.load_pend = 1'b0;
        end else begin
            if (eng_q.load_pend) begin
                eng_d.load_pend = 1'b0;
                if (eng_q.op == OP_READ) begin
                    eng_d.tx   = rdata;
                    eng_d.rcap = rdata;
                end else begin
                    eng_d.tx = '0;
                end
            end
            if (sclk_rise && (eng_q.cnt < CNT_W'(FRAME_W))) begin
                eng_d.sh  = sh_next;
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (eng_q.cnt == CNT_W'(CMD_W - 1)) begin
                    eng_d.op        = sh_next[CMD_W-1 -: 2];
                    eng_d.addr      = sh_next[ADDR_W-1:0];
                    eng_d.load_pend = 1'b1;
                end
                if (eng_q.cnt >= CNT_W'(CMD_W)) begin
                    eng_d.dout = eng_q.tx[DATA_W-1];
                    eng_d.tx   = {eng_q.tx[DATA_W-2:0], 1'b0};
                end
                if (eng_q.cnt == CNT_W'(FRAME_W - 1)) begin
                    eng_d.wdata  = sh_next[DATA_W-1:0];
                    eng_d.wr_stb = (eng_q.op == OP_WRITE);
                    eng_d.rd_stb = (eng_q.op == OP_READ);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign miso    = eng_q.dout;
    assign wr_stb  = eng_q.wr_stb;
    assign rd_stb  = eng_q.rd_stb;
    assign addr    = eng_q.addr;
    assign wdata   = eng_q.wdata;
    assign rcap    = eng_q.rcap;
    assign bit_cnt = eng_q.cnt;
endmodule

// File: rtl/cal_reg_bank.sv
module cal_reg_bank
    import cal_spi_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int DATA_W     = DATA_W_DEF,
    parameter int KEY_W      = KEY_W_DEF,
    parameter int STAT_COUNT = 16,
    parameter int CAL_COUNT  = 32,
    localparam int NUM_REGS  = 2 ** ADDR_W,
    localparam int CAL_BASE  = STAT_COUNT,
    localparam int GEN_BASE  = CAL_BASE + CAL_COUNT,
    localparam int MIR_RD    = NUM_REGS - 4,
    localparam int MIR_WR    = NUM_REGS - 3,
    localparam int CKS_ADDR  = NUM_REGS - 2,
    localparam int KEY_ADDR  = NUM_REGS - 1,
    localparam int GEN_COUNT = MIR_RD - GEN_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rcap,
    output logic [DATA_W-1:0] rdata,
    output logic [KEY_W-1:0]  key_o,
    output logic [DATA_W-1:0] cks_o
);
    typedef struct packed {
        logic [CAL_COUNT-1:0][DATA_W-1:0] cal;
        logic [GEN_COUNT-1:0][DATA_W-1:0] gen;
        logic [KEY_W-1:0]                 key;
        logic [DATA_W-1:0]                mir_rd;
        logic [DATA_W-1:0]                mir_wr;
        logic [DATA_W-1:0]                cks;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  unlocked;

    assign unlocked = (bank_q.key == KEY_W'(UNLOCK_VALUE));

    always_comb begin
        bank_d = bank_q;
        if (wr_stb) begin
            bank_d.mir_wr = wdata;
            if (addr == ADDR_W'(KEY_ADDR)) begin
                bank_d.key = wdata[KEY_W-1:0];
            end
            for (int i = 0; i < CAL_COUNT; i++) begin
                if (unlocked && (addr == ADDR_W'(CAL_BASE + i))) begin
                    bank_d.cal[i] = wdata;
                    // incremental update keeps the sum exact with one adder pair
                    bank_d.cks    = bank_q.cks - bank_q.cal[i] + wdata;
                end
            end
            for (int g = 0; g < GEN_COUNT; g++) begin
                if (addr == ADDR_W'(GEN_BASE + g)) begin
                    bank_d.gen[g] = wdata;
                end
            end
        end
        if (rd_stb) begin
            bank_d.mir_rd = rcap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < ADDR_W'(STAT_COUNT)) begin
            for (int b = 0; b < DATA_W / 8; b++) begin
                rdata[b*8 +: 8] = 8'(addr);
            end
        end
        for (int i = 0; i < CAL_COUNT; i++) begin
            if (addr == ADDR_W'(CAL_BASE + i)) rdata = bank_q.cal[i];
        end
        for (int g = 0; g < GEN_COUNT; g++) begin
            if (addr == ADDR_W'(GEN_BASE + g)) rdata = bank_q.gen[g];
        end
        if (addr == ADDR_W'(MIR_RD))   rdata = bank_q.mir_rd;
        if (addr == ADDR_W'(MIR_WR))   rdata = bank_q.mir_wr;
        if (addr == ADDR_W'(CKS_ADDR)) rdata = bank_q.cks;
        if (addr == ADDR_W'(KEY_ADDR)) rdata = DATA_W'(bank_q.key);
    end

    assign key_o = bank_q.key;
    assign cks_o = bank_q.cks;
endmodule

// File: rtl/cal_spi_port.sv
module cal_spi_port
    import cal_spi_pkg::*;
#(
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int CMD_W       = CMD_W_DEF,
    parameter int KEY_W       = KEY_W_DEF,
    parameter int SYNC_STAGES = 2,
    parameter int STAT_COUNT  = 16,
    parameter int CAL_COUNT   = 32,
    localparam int CNT_W      = $clog2(CMD_W + DATA_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sclk,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic              cs_s;
    logic              rise_s;
    logic              mosi_s;
    logic              wr_stb;
    logic              rd_stb;
    logic [ADDR_W-1:0] frm_addr;
    logic [DATA_W-1:0] frm_wdata;
    logic [DATA_W-1:0] frm_rcap;
    logic [DATA_W-1:0] bank_rdata;
    logic [KEY_W-1:0]  key_val;
    logic [DATA_W-1:0] cks_val;
    logic [CNT_W-1:0]  bit_cnt;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_pin (spi_cs_n),
        .sclk_pin (spi_sclk),
        .mosi_pin (spi_mosi),
        .cs_n_s   (cs_s),
        .sclk_rise(rise_s),
        .mosi_s   (mosi_s)
    );

    spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_s),
        .sclk_rise(rise_s),
        .mosi_s   (mosi_s),
        .rdata    (bank_rdata),
        .miso     (spi_miso),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .addr     (frm_addr),
        .wdata    (frm_wdata),
        .rcap     (frm_rcap),
        .bit_cnt  (bit_cnt)
    );

    cal_reg_bank #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .KEY_W     (KEY_W),
        .STAT_COUNT(STAT_COUNT),
        .CAL_COUNT (CAL_COUNT)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_stb(wr_stb),
        .rd_stb(rd_stb),
        .addr  (frm_addr),
        .wdata (frm_wdata),
        .rcap  (frm_rcap),
        .rdata (bank_rdata),
        .key_o (key_val),
        .cks_o (cks_val)
    );
endmodule

// File: rtl/cal_spi_port_chk.sv
module cal_spi_port_chk
    import cal_spi_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int KEY_W  = KEY_W_DEF,
    parameter int CNT_W  = 6,
    parameter int FRAME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              miso,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] addr,
    input logic [KEY_W-1:0]  key,
    input logic [DATA_W-1:0] cks,
    input logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [ADDR_W-1:0] CKS_ADDR = ADDR_W'((2 ** ADDR_W) - 2);

    p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso);

    p_commit_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |-> (bit_cnt == CNT_W'(FRAME_W)));

    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_stb}));

    p_locked_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (key != KEY_W'(UNLOCK_VALUE))) |=> $stable(cks));

    p_sum_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (addr == CKS_ADDR)) |=> $stable(cks));

    p_sum_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cks));
endmodule

bind cal_spi_port cal_spi_port_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .CNT_W  (CNT_W),
    .FRAME_W(CMD_W + DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_s   (cs_s),
    .miso   (spi_miso),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .addr   (frm_addr),
    .key    (key_val),
    .cks    (cks_val),
    .bit_cnt(bit_cnt)
);

// File: tb/sim_cal_spi_port.sv
`timescale 1ns/1ps
module sim_cal_spi_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sclk = 1'b0;
    logic spi_mosi = 1'b0;
    logic spi_miso;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_spi_port u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one frame of nbits serial clocks; bits beyond 32 send ones
    task automatic frame(input logic [1:0] op, input logic [5:0] addr, input logic [23:0] data,
                         input int nbits, output logic [23:0] rd, output logic cmd_quiet);
        logic [31:0] f;
        f = {op, addr, data};
        rd = '0;
        cmd_quiet = 1'b1;
        spi_cs_n = 1'b0;
        wait_cyc(HALF_BIT);
        for (int k = 0; k < nbits; k++) begin
            spi_mosi = (k < 32) ? f[31-k] : 1'b1;
            wait_cyc(HALF_BIT);
            spi_sclk = 1'b1;
            wait_cyc(HALF_BIT);
            if (k < 8) begin
                if (spi_miso !== 1'b0) cmd_quiet = 1'b0;
            end else if (k < 32) begin
                rd = {rd[22:0], spi_miso};
            end
            spi_sclk = 1'b0;
        end
        spi_mosi = 1'b0;
        wait_cyc(HALF_BIT);
        spi_cs_n = 1'b1;
        wait_cyc(HALF_BIT);
    endtask

    task automatic wr(input logic [5:0] a, input logic [23:0] d);
        logic [23:0] r;
        logic q;
        frame(2'b01, a, d, 32, r, q);
    endtask

    task automatic rd(input logic [5:0] a, output logic [23:0] d);
        logic q;
        frame(2'b00, a, 24'h0, 32, d, q);
    endtask

    task automatic t_reset;
        logic [23:0] v;
        check("R11 idle output after reset", {23'h0, spi_miso}, 24'h0);
        rd(6'h3F, v); check("R4 key resets to zero", v, 24'h0);
        rd(6'h3E, v); check("R5 checksum resets to zero", v, 24'h0);
        rd(6'h05, v); check("R8 status word 0x05", v, 24'h050505);
        check("R11 idle output after frame", {23'h0, spi_miso}, 24'h0);
    endtask

    task automatic t_locked;
        logic [23:0] v;
        wr(6'h10, 24'h111111);
        rd(6'h10, v); check("R4 locked calibration write dropped", v, 24'h0);
        rd(6'h3D, v); check("R7 write mirror holds rejected data", v, 24'h111111);
    endtask

    task automatic t_unlock_sum;
        logic [23:0] v;
        logic q;
        wr(6'h3F, 24'hABCD55);
        frame(2'b00, 6'h3F, 24'h0, 32, v, q);
        check("R2 key reads zero padded", v, 24'h000055);
        check("R2 output low in command phase", {23'h0, q}, 24'h1);
        wr(6'h10, 24'h123456);
        rd(6'h10, v); check("R1 R4 unlocked write read back", v, 24'h123456);
        wr(6'h2F, 24'hF00000);
        rd(6'h3E, v); check("R5 checksum wraps", v, 24'h023456);
        wr(6'h10, 24'h000001);
        rd(6'h3E, v); check("R5 checksum after overwrite", v, 24'hF00001);
    endtask

    task automatic t_read_mirror;
        logic [23:0] v;
        rd(6'h2F, v); check("R2 read upper calibration reg", v, 24'hF00000);
        rd(6'h3C, v); check("R6 read mirror", v, 24'hF00000);
    endtask

    task automatic t_abort;
        logic [23:0] v;
        logic q;
        wr(6'h30, 24'h0A0B0C);
        frame(2'b01, 6'h30, 24'hABCDEF, 20, v, q);
        rd(6'h30, v); check("R3 abort after 20 clocks", v, 24'h0A0B0C);
        frame(2'b01, 6'h30, 24'hABCDEF, 31, v, q);
        rd(6'h30, v); check("R3 abort after 31 clocks", v, 24'h0A0B0C);
        frame(2'b01, 6'h31, 24'h00FF00, 40, v, q);
        rd(6'h31, v); check("R3 extra clocks ignored", v, 24'h00FF00);
    endtask

    task automatic t_bad_op;
        logic [23:0] v;
        logic q;
        frame(2'b10, 6'h30, 24'h777777, 32, v, q);
        check("R10 output low for opcode 10", v, 24'h0);
        frame(2'b11, 6'h05, 24'h777777, 32, v, q);
        check("R10 output low for opcode 11", v, 24'h0);
        rd(6'h30, v); check("R10 target unchanged", v, 24'h0A0B0C);
        rd(6'h3D, v); check("R10 write mirror unchanged", v, 24'h00FF00);
    endtask

    task automatic t_readonly;
        logic [23:0] v;
        wr(6'h3E, 24'h000000);
        rd(6'h3E, v); check("R8 checksum ignores writes", v, 24'hF00001);
        wr(6'h05, 24'h999999);
        rd(6'h05, v); check("R8 status ignores writes", v, 24'h050505);
        rd(6'h0F, v); check("R8 status word 0x0F", v, 24'h0F0F0F);
    endtask

    task automatic t_relock;
        logic [23:0] v;
        wr(6'h3F, 24'h000012);
        rd(6'h3F, v); check("R4 key accepts lock value", v, 24'h000012);
        wr(6'h10, 24'h555555);
        rd(6'h10, v); check("R4 relocked write dropped", v, 24'h000001);
        wr(6'h3B, 24'h13579B);
        rd(6'h3B, v); check("R9 storage writable while locked", v, 24'h13579B);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_locked();
        t_unlock_sum();
        t_read_mirror();
        t_abort();
        t_bad_op();
        t_readonly();
        t_relock();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule